// File: doc/BRIEF.md
# Vector Coprocessor Issue Controller

This block connects an in-order scalar core to a vector execution unit. The core presents a command with a request strobe. The command carries three 32-bit operands, a 6-bit opcode and a 15-bit flag set. The controller has two states, WAIT and EXECUTE. It captures the command, starts the vector datapath, and holds the core frozen for as many cycles as the operation needs. It then answers with a single-cycle acknowledge that carries a 32-bit result and a 5-bit flag set.

While a datapath operation is in flight, the controller tells the core to discard its scalar register writeback, so a vector result never lands in a scalar register. The controller also owns three local vector control registers: the active element count, the element width and the resume index. Two local opcodes update these registers without involving the datapath, and their answer is written back to a scalar register. The datapath itself is outside this block. It is driven by a start pulse and reports back with a done strobe.

Top module: `vec_issue_ctrl`

## Requirements
- R1: After reset the controller is in WAIT: `core_stall`, `req_ack`, `dp_start` and `wb_block` are 0, and `vl`, `vsew` and `vstart` are 0.
- R2: A request seen in WAIT with a datapath opcode (any opcode other than 0x38 or 0x39) is accepted at the next clock edge. In the following cycle `dp_start` is high for exactly one cycle, and `dp_opa`, `dp_opb`, `dp_opc`, `dp_opcode` and `dp_cmd_flags` show the captured command. These outputs stay unchanged until the acknowledge.
- R3: `core_stall` is high in the cycle a request is presented in WAIT, and in every EXECUTE cycle before completion. It is low in the acknowledge cycle and while idle in WAIT.
- R4: In EXECUTE, `req_ack` rises in the same cycle that `dp_done` is high and lasts exactly one cycle. `rsp_result` and `rsp_flags` then equal `dp_result` and `dp_res_flags`. A `dp_done` while in WAIT has no effect.
- R5: A datapath operation may last any number of cycles from one upward. The controller stays in EXECUTE with the stall held until `dp_done` arrives.
- R6: No request is accepted in EXECUTE or in the acknowledge cycle. A request held high through an acknowledge is accepted at the edge after the acknowledge cycle.
- R7: `wb_block` is high in every EXECUTE cycle of a datapath operation, including its acknowledge cycle. It is low in WAIT and for the local opcodes 0x38 and 0x39.
- R8: Opcode 0x38 (configure) takes a requested count from operand A and a width code from operand B bits [1:0]: code 0 is 8-bit, 1 is 16-bit, 2 is 32-bit. It sets `vsew` to the code, sets `vl` to min(request, VLEN_BITS/width) and clears `vstart`. It acknowledges in the cycle after acceptance with the granted count as result and flags 0, and raises no `dp_start`.
- R9: A configure with width code 3 sets `vl` to 0, keeps `vsew`, clears `vstart`, and answers with result 0 and `rsp_flags` bit 0 set.
- R10: Opcode 0x39 loads `vstart` with the low VL_W bits of operand A (VL_W is 3 by default). It acknowledges in the cycle after acceptance with that value as result.
- R11: `vstart` reads 0 after any datapath operation has been acknowledged.
- R12: `rsp_result` and `rsp_flags` are 0 in every cycle without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core command strobe |
| req_opa | input | 32 | Operand A |
| req_opb | input | 32 | Operand B |
| req_opc | input | 32 | Operand C |
| req_opcode | input | 6 | Operation code |
| req_flags | input | 15 | Command flag set |
| req_ack | output | 1 | One-cycle completion acknowledge |
| rsp_result | output | 32 | Result, valid with acknowledge |
| rsp_flags | output | 5 | Result flags, valid with acknowledge |
| core_stall | output | 1 | Freeze request toward the core |
| wb_block | output | 1 | Suppress scalar register writeback |
| dp_start | output | 1 | Datapath start pulse |
| dp_opa | output | 32 | Captured operand A to datapath |
| dp_opb | output | 32 | Captured operand B to datapath |
| dp_opc | output | 32 | Captured operand C to datapath |
| dp_opcode | output | 6 | Captured opcode to datapath |
| dp_cmd_flags | output | 15 | Captured command flags to datapath |
| dp_done | input | 1 | Datapath completion strobe |
| dp_result | input | 32 | Datapath result |
| dp_res_flags | input | 5 | Datapath result flags |
| vl | output | 3 | Active element count |
| vsew | output | 2 | Element width code |
| vstart | output | 3 | Resume index |

## Verification
A datapath command presented in one cycle gives `dp_start` one cycle later. Its acknowledge, result and flags appear combinationally in the very cycle the bench raises `dp_done`. Local opcodes acknowledge exactly one cycle after the request cycle, and the control registers show their new values from that same cycle. The bench drives inputs 1 ns after each rising edge and samples at the cycle midpoint, so each check lands in the one cycle the requirement names. Longer operations are followed cycle by cycle to confirm that the stall holds, the result stays zero and the start does not repeat.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int OPND_W = 32;
    localparam int OPC_W  = 6;
    localparam int RFLG_W = 15;
    localparam int RES_W  = 32;
    localparam int SFLG_W = 5;

    localparam logic [OPC_W-1:0] OPC_SETCFG   = 6'h38;
    localparam logic [OPC_W-1:0] OPC_SETSTART = 6'h39;

    localparam logic [1:0] WCODE_BAD = 2'd3;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_EXEC = 1'b1
    } vic_state_e;

    typedef struct packed {
        logic [OPND_W-1:0] a;
        logic [OPND_W-1:0] b;
        logic [OPND_W-1:0] c;
        logic [OPC_W-1:0]  opc;
        logic [RFLG_W-1:0] flags;
    } vic_cmd_t;

    typedef struct packed {
        logic [RES_W-1:0]  data;
        logic [SFLG_W-1:0] flags;
    } vic_rsp_t;

    // Opcodes served inside the controller, never sent to the datapath
    function automatic logic is_local_op(input logic [OPC_W-1:0] opc);
        return (opc == OPC_SETCFG) || (opc == OPC_SETSTART);
    endfunction

    // Element capacity of one register for a given width code
    function automatic logic [OPND_W-1:0] elem_cap(input int vlen, input logic [1:0] code);
        return OPND_W'(vlen) >> (3 + int'(code));
    endfunction

endpackage

// File: rtl/vic_fsm.sv
module vic_fsm
    import vic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_local,
    input  logic done_in,
    output logic accept,
    output logic finish,
    output logic cur_local,
    output logic start_pulse,
    output logic stall,
    output logic wb_suppress
);

    vic_state_e state_q;

    always_comb begin
        accept      = (state_q == ST_WAIT) && req_valid;
        finish      = (state_q == ST_EXEC) && (cur_local || done_in);
        stall       = accept || ((state_q == ST_EXEC) && !finish);
        wb_suppress = (state_q == ST_EXEC) && !cur_local;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_WAIT;
            cur_local   <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= accept && !req_local;
            if (accept) begin
                state_q   <= ST_EXEC;
                cur_local <= req_local;
            end else if (finish) begin
                state_q   <= ST_WAIT;
            end
        end
    end

endmodule

// File: rtl/vic_csr.sv
module vic_csr
    import vic_pkg::*;
#(
    parameter int VLEN_BITS = 32,
    parameter int VL_W      = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  vic_cmd_t        cmd,
    input  logic            data_done,
    output logic [VL_W-1:0] vl_q,
    output logic [1:0]      sew_q,
    output logic [VL_W-1:0] vstart_q,
    output vic_rsp_t        loc_rsp
);

    logic [1:0]        wcode;
    logic [OPND_W-1:0] cap;
    logic [OPND_W-1:0] grant;
    logic              bad_width;

    always_comb begin
        wcode     = cmd.b[1:0];
        bad_width = (wcode == WCODE_BAD);
        cap       = elem_cap(VLEN_BITS, wcode);
        grant     = (cmd.a < cap) ? cmd.a : cap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vl_q     <= '0;
            sew_q    <= '0;
            vstart_q <= '0;
            loc_rsp  <= '0;
        end else if (accept && cmd.opc == OPC_SETCFG) begin
            vstart_q <= '0;
            if (bad_width) begin
                vl_q    <= '0;
                loc_rsp <= '{data: '0, flags: SFLG_W'(1)};
            end else begin
                vl_q    <= grant[VL_W-1:0];
                sew_q   <= wcode;
                loc_rsp <= '{data: grant, flags: '0};
            end
        end else if (accept && cmd.opc == OPC_SETSTART) begin
            vstart_q <= cmd.a[VL_W-1:0];
            loc_rsp  <= '{data: RES_W'(cmd.a[VL_W-1:0]), flags: '0};
        end else if (data_done) begin
            vstart_q <= '0;
        end
    end

endmodule

// File: rtl/vic_resp.sv
module vic_resp
    import vic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  vic_cmd_t cmd_in,
    input  logic     finish,
    input  logic     cur_local,
    input  vic_rsp_t dp_rsp,
    input  vic_rsp_t loc_rsp,
    output vic_cmd_t cmd_q,
    output vic_rsp_t rsp_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (accept) begin
            cmd_q <= cmd_in;
        end
    end

    always_comb begin
        if (!finish)        rsp_out = '0;
        else if (cur_local) rsp_out = loc_rsp;
        else                rsp_out = dp_rsp;
    end

endmodule

// File: rtl/vec_issue_ctrl.sv
module vec_issue_ctrl
    import vic_pkg::*;
#(
    parameter int VLEN_BITS = 32,
    localparam int VL_W     = $clog2(VLEN_BITS / 8) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [OPND_W-1:0] req_opa,
    input  logic [OPND_W-1:0] req_opb,
    input  logic [OPND_W-1:0] req_opc,
    input  logic [OPC_W-1:0]  req_opcode,
    input  logic [RFLG_W-1:0] req_flags,
    output logic              req_ack,
    output logic [RES_W-1:0]  rsp_result,
    output logic [SFLG_W-1:0] rsp_flags,
    output logic              core_stall,
    output logic              wb_block,
    output logic              dp_start,
    output logic [OPND_W-1:0] dp_opa,
    output logic [OPND_W-1:0] dp_opb,
    output logic [OPND_W-1:0] dp_opc,
    output logic [OPC_W-1:0]  dp_opcode,
    output logic [RFLG_W-1:0] dp_cmd_flags,
    input  logic              dp_done,
    input  logic [RES_W-1:0]  dp_result,
    input  logic [SFLG_W-1:0] dp_res_flags,
    output logic [VL_W-1:0]   vl,
    output logic [1:0]        vsew,
    output logic [VL_W-1:0]   vstart
);

    vic_cmd_t cmd_in, cmd_q;
    vic_rsp_t dp_rsp, loc_rsp, rsp_out;
    logic     accept, finish, cur_local;

    assign cmd_in = '{a: req_opa, b: req_opb, c: req_opc, opc: req_opcode, flags: req_flags};
    assign dp_rsp = '{data: dp_result, flags: dp_res_flags};

    vic_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_local  (is_local_op(req_opcode)),
        .done_in    (dp_done),
        .accept     (accept),
        .finish     (finish),
        .cur_local  (cur_local),
        .start_pulse(dp_start),
        .stall      (core_stall),
        .wb_suppress(wb_block)
    );

    vic_csr #(.VLEN_BITS(VLEN_BITS), .VL_W(VL_W)) u_csr (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .cmd      (cmd_in),
        .data_done(finish && !cur_local),
        .vl_q     (vl),
        .sew_q    (vsew),
        .vstart_q (vstart),
        .loc_rsp  (loc_rsp)
    );

    vic_resp u_resp (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .cmd_in   (cmd_in),
        .finish   (finish),
        .cur_local(cur_local),
        .dp_rsp   (dp_rsp),
        .loc_rsp  (loc_rsp),
        .cmd_q    (cmd_q),
        .rsp_out  (rsp_out)
    );

    assign req_ack      = finish;
    assign rsp_result   = rsp_out.data;
    assign rsp_flags    = rsp_out.flags;
    assign dp_opa       = cmd_q.a;
    assign dp_opb       = cmd_q.b;
    assign dp_opc       = cmd_q.c;
    assign dp_opcode    = cmd_q.opc;
    assign dp_cmd_flags = cmd_q.flags;

endmodule

// File: rtl/vic_checker.sv
module vic_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_ack,
    input logic       core_stall,
    input logic       dp_start,
    input logic       dp_done,
    input logic       wb_block,
    input logic [5:0] dp_opcode
);

    assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    assert_ack_needs_done_R4: assert property (@(posedge clk) disable iff (rst)
        (req_ack && wb_block) |-> dp_done);

    assert_ack_releases_R3: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> !core_stall);

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        dp_start |=> !dp_start);

    assert_start_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (dp_start && !req_ack) |-> core_stall);

    assert_cmd_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (dp_start && !req_ack) |=> $stable(dp_opcode));

    assert_no_accept_on_ack_R6: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !dp_start);

    assert_start_blocks_wb_R7: assert property (@(posedge clk) disable iff (rst)
        dp_start |-> wb_block);

endmodule

bind vec_issue_ctrl vic_checker u_vic_checker (
    .clk       (clk),
    .rst       (rst),
    .req_ack   (req_ack),
    .core_stall(core_stall),
    .dp_start  (dp_start),
    .dp_done   (dp_done),
    .wb_block  (wb_block),
    .dp_opcode (dp_opcode)
);

// File: tb/vec_issue_ctrl_bench.sv
module vec_issue_ctrl_bench;

    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [7:0]  lat;
        logic [31:0] dres;
        logic [4:0]  dflg;
        logic [31:0] eres;
        logic [4:0]  eflg;
        logic [2:0]  evl;
        logic [1:0]  esew;
        logic [2:0]  evst;
    } vec_t;

    localparam int NROWS = 10;
    localparam vec_t TBL [NROWS] = '{
        '{6'h38, 32'd10, 32'd0, 8'd0,  32'd0,          5'd0,  32'd4,          5'd0,  3'd4, 2'd0, 3'd0},
        '{6'h39, 32'd3,  32'd0, 8'd0,  32'd0,          5'd0,  32'd3,          5'd0,  3'd4, 2'd0, 3'd3},
        '{6'h01, 32'd7,  32'd9, 8'd1,  32'hDEADBEEF,   5'h11, 32'hDEADBEEF,   5'h11, 3'd4, 2'd0, 3'd0},
        '{6'h38, 32'd1,  32'd1, 8'd0,  32'd0,          5'd0,  32'd1,          5'd0,  3'd1, 2'd1, 3'd0},
        '{6'h38, 32'd7,  32'd2, 8'd0,  32'd0,          5'd0,  32'd1,          5'd0,  3'd1, 2'd2, 3'd0},
        '{6'h39, 32'd13, 32'd0, 8'd0,  32'd0,          5'd0,  32'd5,          5'd0,  3'd1, 2'd2, 3'd5},
        '{6'h12, 32'd44, 32'd1, 8'd6,  32'h12345678,   5'h02, 32'h12345678,   5'h02, 3'd1, 2'd2, 3'd0},
        '{6'h38, 32'd9,  32'd3, 8'd0,  32'd0,          5'd0,  32'd0,          5'd1,  3'd0, 2'd2, 3'd0},
        '{6'h38, 32'd0,  32'd1, 8'd0,  32'd0,          5'd0,  32'd0,          5'd0,  3'd0, 2'd1, 3'd0},
        '{6'h05, 32'd2,  32'd3, 8'd40, 32'h0000A5A5,   5'h00, 32'h0000A5A5,   5'h00, 3'd0, 2'd1, 3'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_opa = '0, req_opb = '0, req_opc = '0;
    logic [5:0]  req_opcode = '0;
    logic [14:0] req_flags = '0;
    logic        req_ack;
    logic [31:0] rsp_result;
    logic [4:0]  rsp_flags;
    logic        core_stall, wb_block, dp_start;
    logic [31:0] dp_opa, dp_opb, dp_opc;
    logic [5:0]  dp_opcode;
    logic [14:0] dp_cmd_flags;
    logic        dp_done = 1'b0;
    logic [31:0] dp_result = '0;
    logic [4:0]  dp_res_flags = '0;
    logic [2:0]  vl, vstart;
    logic [1:0]  vsew;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vec_issue_ctrl u_vec_issue_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_opa(req_opa), .req_opb(req_opb), .req_opc(req_opc),
        .req_opcode(req_opcode), .req_flags(req_flags),
        .req_ack(req_ack), .rsp_result(rsp_result), .rsp_flags(rsp_flags),
        .core_stall(core_stall), .wb_block(wb_block), .dp_start(dp_start),
        .dp_opa(dp_opa), .dp_opb(dp_opb), .dp_opc(dp_opc),
        .dp_opcode(dp_opcode), .dp_cmd_flags(dp_cmd_flags),
        .dp_done(dp_done), .dp_result(dp_result), .dp_res_flags(dp_res_flags),
        .vl(vl), .vsew(vsew), .vstart(vstart)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Entered 1 ns after a rising edge with the controller idle in WAIT
    task automatic issue(input vec_t v);
        bit local_op;
        local_op   = (v.op == 6'h38) || (v.op == 6'h39);
        req_opcode = v.op;
        req_opa    = v.a;
        req_opb    = v.b;
        req_opc    = ~v.a;
        req_flags  = {v.op, 9'h0A5};
        req_valid  = 1'b1;
        dp_result  = v.dres;
        dp_res_flags = v.dflg;
        #1;
        chk("R3 stall in request cycle", core_stall, 1);
        chk("R7 no wb block in WAIT", wb_block, 0);
        tick();
        req_valid = 1'b0;
        if (local_op) begin
            chk("R8/R10 local ack one cycle after request", req_ack, 1);
            chk("R8/R9/R10 local result", rsp_result, v.eres);
            chk("R9 local flags", rsp_flags, v.eflg);
            chk("R8 no datapath start", dp_start, 0);
            chk("R7 local op not blocked", wb_block, 0);
            chk("R3 stall released on ack", core_stall, 0);
            chk("R8 vl", vl, v.evl);
            chk("R8/R9 vsew", vsew, v.esew);
            chk("R10 vstart", vstart, v.evst);
            tick();
        end else begin
            for (int i = 1; i < v.lat; i++) begin
                chk("R2 start pulse only first cycle", dp_start, (i == 1));
                chk("R2 opcode to datapath", dp_opcode, v.op);
                chk("R2 operand A to datapath", dp_opa, v.a);
                chk("R2 operand C to datapath", dp_opc, ~v.a);
                chk("R5 stall held while busy", core_stall, 1);
                chk("R7 wb blocked while busy", wb_block, 1);
                chk("R12 result zero without ack", rsp_result, 0);
                chk("R4 no ack before done", req_ack, 0);
                tick();
            end
            dp_done = 1'b1;
            #1;
            chk("R4 ack with done", req_ack, 1);
            chk("R4 result from datapath", rsp_result, v.eres);
            chk("R4 flags from datapath", rsp_flags, v.eflg);
            chk("R3 stall low in ack cycle", core_stall, 0);
            chk("R7 wb blocked in ack cycle", wb_block, 1);
            chk("R2 start seen when single cycle", dp_start, (v.lat == 1));
            chk("R2 flags to datapath", dp_cmd_flags, {v.op, 9'h0A5});
            tick();
            dp_done = 1'b0;
            #1;
            chk("R11 vstart cleared after vector op", vstart, v.evst);
            chk("R8 vl kept across vector op", vl, v.evl);
        end
        chk("R4 ack is a single pulse", req_ack, 0);
        chk("R3 idle no stall", core_stall, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset stall", core_stall, 0);
        chk("R1 reset ack", req_ack, 0);
        chk("R1 reset start", dp_start, 0);
        chk("R1 reset wb block", wb_block, 0);
        chk("R1 reset vl", vl, 0);
        chk("R1 reset vsew", vsew, 0);
        chk("R1 reset vstart", vstart, 0);
        rst = 1'b0;
        tick();

        for (int r = 0; r < NROWS; r++) begin
            issue(TBL[r]);
        end

        // R4: done strobe while idle is ignored
        dp_done = 1'b1;
        dp_result = 32'h0BAD0BAD;
        #1;
        chk("R4 done in WAIT gives no ack", req_ack, 0);
        chk("R12 no result in WAIT", rsp_result, 0);
        chk("R4 done in WAIT no stall", core_stall, 0);
        tick();
        dp_done = 1'b0;
        chk("R4 done in WAIT no start", dp_start, 0);

        // R6: request held through an acknowledge
        req_opcode = 6'h22;
        req_opa    = 32'h11;
        req_valid  = 1'b1;
        tick();
        chk("R6 first accepted", dp_start, 1);
        chk("R6 request in EXEC keeps stall", core_stall, 1);
        tick();
        chk("R6 no second start while busy", dp_start, 0);
        dp_done = 1'b1;
        dp_result = 32'h77;
        #1;
        chk("R6 ack of first", req_ack, 1);
        tick();
        dp_done = 1'b0;
        #1;
        chk("R6 no start in cycle after ack", dp_start, 0);
        chk("R6 held request stalls again", core_stall, 1);
        tick();
        req_valid = 1'b0;
        chk("R6 held request accepted after ack", dp_start, 1);
        dp_done = 1'b1;
        #1;
        chk("R6 second ack", req_ack, 1);
        tick();
        dp_done = 1'b0;
        #1;
        chk("R6 back to idle", core_stall, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule